// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block generates one pulse-width-modulated output from the peripheral clock. A power-of-two prescaler slows the clock by 2^d, where d runs from 0 to 24. Each prescaled tick advances a 10-bit period counter. The output is high while that counter is below a programmed high-time count and low for the rest of the period.

Software reaches the block through a small synchronous register port that holds two words. The control word carries the run bit, the update-hold bit and the prescaler exponent. The count word carries the period length and the high-time length. Values written by software land in staging (shadow) copies. The running waveform picks them up only after software releases the update-hold bit. This lets a new period, high time and prescaler change together, without a torn period. The block refuses settings that would make a period or high time of zero.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset both register words read as zero and `pwm_out` is low.
- R2: Address bit 2 selects the word: 0 is the control word and 1 is the count word.
  - Control word: run bit at bit 0, update-hold bit at bit 11, exponent bit 0 at bit 15, exponent bits 4:1 at bits 19:16.
  - Count word: period length at bits 25:16 and high-time length at bits 9:0.
  - Reads return the staged fields, and every other bit reads as zero.
- R3: An exponent write above 24 is stored and read back as 24.
- R4: A count-word write whose period field or high-time field is zero is ignored, and the previously staged count word still reads back.
- R5: Writing the run bit as 1 has no effect while the working period or working high time is zero, so the run bit reads back 0 and the output stays low.
- R6: Once running, each count lasts 2^d clocks and a period spans the period length in counts. Starting in the first clock after the run bit is set, at count 0, the output is high while the count is below the high time.
- R7: When the high time is greater than or equal to the period length, the output stays high for as long as the channel runs.
- R8: While the update-hold bit is set, staged writes do not change the running waveform.
- R9: When a control write clears the update-hold bit, the staged values take over the waveform. If the channel is running, this happens at the next period boundary. If it is stopped, it happens one clock later.
- R10: A control write with the run bit at 0 drives the output low from the next clock. A later run restarts at count 0 with a fresh prescaler.
- R11: A register write takes effect at the clock edge that samples it and is visible in read data from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bit 2 selects the word |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
The hardest case to reach is a staged change that is released mid-period while the channel runs. It should switch the waveform exactly at the next period boundary, neither earlier nor later.

The stimulus starts the channel with one setting and raises the update-hold bit. It writes a clearly different period and high time, then measures the old duty over two whole periods to show nothing leaked. It then releases the hold at an arbitrary phase. After that it waits for the low-to-high edge that marks the boundary and checks the new pattern clock by clock from that point.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    // word select and field positions of the register port
    localparam int REG_SEL_BIT   = 2;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_HOLD_BIT = 11;
    localparam int CTRL_EXP0_BIT = 15;
    localparam int CTRL_EXPH_LO  = 16;
    localparam int CTRL_EXPH_HI  = 19;
    localparam int CNT_PER_LO    = 16;
    localparam int CNT_HIGH_LO   = 0;

    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_COUNT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_tmr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 10,
    parameter int MAX_EXP = 24,
    parameter int EXP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              active_ok,
    output logic [31:0]       bus_rdata,
    output logic              run,
    output logic              hold,
    output logic              hold_fall,
    output logic [EXP_W-1:0]  stg_exp,
    output logic [CNT_W-1:0]  stg_per,
    output logic [CNT_W-1:0]  stg_high
);

    typedef struct packed {
        logic             run;
        logic             hold;
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic [4:0]       exp_raw;
    logic [CNT_W-1:0] per_w, high_w;
    logic             unused_in;

    assign unused_in = ^{bus_wdata, bus_addr};

    always_comb begin
        regs_d    = regs_q;
        hold_fall = 1'b0;
        sel       = reg_sel_e'(bus_addr[REG_SEL_BIT]);
        exp_raw   = {bus_wdata[CTRL_EXPH_HI:CTRL_EXPH_LO], bus_wdata[CTRL_EXP0_BIT]};
        per_w     = bus_wdata[CNT_PER_LO +: CNT_W];
        high_w    = bus_wdata[CNT_HIGH_LO +: CNT_W];

        if (bus_we && sel == SEL_CTRL) begin
            regs_d.run  = bus_wdata[CTRL_RUN_BIT] & active_ok;
            regs_d.hold = bus_wdata[CTRL_HOLD_BIT];
            hold_fall   = regs_q.hold & ~bus_wdata[CTRL_HOLD_BIT];
            if (int'(exp_raw) > MAX_EXP) begin
                regs_d.exp = EXP_W'(MAX_EXP);
            end else begin
                regs_d.exp = EXP_W'(exp_raw);
            end
        end

        if (bus_we && sel == SEL_COUNT) begin
            if (per_w != '0 && high_w != '0) begin
                regs_d.per  = per_w;
                regs_d.high = high_w;
            end
        end

        bus_rdata = '0;
        if (sel == SEL_CTRL) begin
            bus_rdata[CTRL_RUN_BIT]                = regs_q.run;
            bus_rdata[CTRL_HOLD_BIT]               = regs_q.hold;
            bus_rdata[CTRL_EXP0_BIT]               = regs_q.exp[0];
            bus_rdata[CTRL_EXPH_HI:CTRL_EXPH_LO]   = 4'(regs_q.exp >> 1);
        end else begin
            bus_rdata[CNT_PER_LO +: CNT_W]  = regs_q.per;
            bus_rdata[CNT_HIGH_LO +: CNT_W] = regs_q.high;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run      = regs_q.run;
    assign hold     = regs_q.hold;
    assign stg_exp  = regs_q.exp;
    assign stg_per  = regs_q.per;
    assign stg_high = regs_q.high;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int EXP_W = 5,
    parameter int PRE_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask  = ~({PRE_W{1'b1}} << exp);
        tick  = run && ((pre_q.cnt & mask) == mask);
        pre_d = pre_q;
        if (!run || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
    parameter int CNT_W = 10,
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             hold_fall,
    input  logic [CNT_W-1:0] stg_per,
    input  logic [CNT_W-1:0] stg_high,
    input  logic [EXP_W-1:0] stg_exp,
    output logic             pwm_out,
    output logic             active_ok,
    output logic [EXP_W-1:0] act_exp,
    output logic             pend,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_high,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] cnt;
    } per_t;

    per_t per_d, per_q;
    logic last, boundary, load;

    always_comb begin
        per_d    = per_q;
        last     = (per_q.cnt == per_q.per - CNT_W'(1));
        boundary = run & tick & last;
        load     = per_q.pend & (~run | boundary);

        if (!run) begin
            per_d.cnt = '0;
        end else if (tick) begin
            per_d.cnt = last ? '0 : per_q.cnt + CNT_W'(1);
        end

        if (load) begin
            per_d.per  = stg_per;
            per_d.high = stg_high;
            per_d.exp  = stg_exp;
            per_d.pend = 1'b0;
        end
        if (hold_fall) begin
            per_d.pend = 1'b1;
        end

        pwm_out   = run & (per_q.cnt < per_q.high);
        active_ok = (per_q.per != '0) & (per_q.high != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else begin
            per_q <= per_d;
        end
    end

    assign act_exp  = per_q.exp;
    assign pend     = per_q.pend;
    assign act_per  = per_q.per;
    assign act_high = per_q.high;
    assign cnt      = per_q.cnt;

endmodule

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch #(
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 10,
    parameter int MAX_EXP = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);

    localparam int EXP_W = $clog2(MAX_EXP + 1);
    localparam int PRE_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic             run_w, hold_w, hold_fall_w, active_ok_w, tick_w, pend_w;
    logic [EXP_W-1:0] stg_exp_w, act_exp_w;
    logic [CNT_W-1:0] stg_per_w, stg_high_w, act_per_w, act_high_w, cnt_w;

    pwm_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .MAX_EXP(MAX_EXP),
        .EXP_W  (EXP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .active_ok(active_ok_w),
        .bus_rdata(bus_rdata),
        .run      (run_w),
        .hold     (hold_w),
        .hold_fall(hold_fall_w),
        .stg_exp  (stg_exp_w),
        .stg_per  (stg_per_w),
        .stg_high (stg_high_w)
    );

    pwm_prescaler #(
        .EXP_W(EXP_W),
        .PRE_W(PRE_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_w),
        .exp  (act_exp_w),
        .tick (tick_w)
    );

    pwm_period #(
        .CNT_W(CNT_W),
        .EXP_W(EXP_W)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .tick     (tick_w),
        .hold_fall(hold_fall_w),
        .stg_per  (stg_per_w),
        .stg_high (stg_high_w),
        .stg_exp  (stg_exp_w),
        .pwm_out  (pwm_out),
        .active_ok(active_ok_w),
        .act_exp  (act_exp_w),
        .pend     (pend_w),
        .act_per  (act_per_w),
        .act_high (act_high_w),
        .cnt      (cnt_w)
    );

endmodule

// File: rtl/pwm_timer_ch_chk.sv
module pwm_timer_ch_chk
    import pwm_tmr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 10,
    parameter int MAX_EXP = 24,
    parameter int EXP_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              pwm_out,
    input logic              run,
    input logic              hold,
    input logic              pend,
    input logic [CNT_W-1:0]  act_per,
    input logic [CNT_W-1:0]  act_high,
    input logic [CNT_W-1:0]  cnt,
    input logic [EXP_W-1:0]  stg_exp,
    input logic [CNT_W-1:0]  stg_per
);

    logic unused_chk;
    assign unused_chk = ^{bus_wdata, bus_addr};

    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr[REG_SEL_BIT] == 1'b0);

    AST_STOP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[CTRL_RUN_BIT]) |=> !pwm_out); // R10

    AST_RUN_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (act_per != '0 && act_high != '0)); // R5

    AST_EXP_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        stg_exp <= EXP_W'(MAX_EXP)); // R3

    AST_NO_ZERO_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stg_per) |-> stg_per != '0); // R4

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pend) |=> ($stable(act_per) && $stable(act_high))); // R8

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt < act_per); // R6

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_high >= act_per) |-> pwm_out); // R7

    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (hold == $past(bus_wdata[CTRL_HOLD_BIT]))); // R11

endmodule

bind pwm_timer_ch pwm_timer_ch_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .MAX_EXP(MAX_EXP),
    .EXP_W  (EXP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pwm_out  (pwm_out),
    .run      (run_w),
    .hold     (hold_w),
    .pend     (pend_w),
    .act_per  (act_per_w),
    .act_high (act_high_w),
    .cnt      (cnt_w),
    .stg_exp  (stg_exp_w),
    .stg_per  (stg_per_w)
);

// File: tb/tb_pwm_timer_ch.sv
`timescale 1ns/1ps
module tb_pwm_timer_ch;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_timer_ch dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_out  (pwm_out)
    );

    // stimulus / expected table: period, high time, exponent, requirement
    localparam int NV = 6;
    localparam int V_PER [NV] = '{10, 7, 12, 5, 9, 1};
    localparam int V_HIGH[NV] = '{3, 7, 20, 1, 4, 1};
    localparam int V_EXP [NV] = '{0, 0, 1, 2, 3, 0};
    localparam string V_REQ[NV] = '{"R6", "R7", "R7", "R6", "R6", "R7"};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit run, input bit hold, input int d);
        logic [31:0] v = '0;
        v[0]     = run;
        v[11]    = hold;
        v[15]    = d[0];
        v[19:16] = 4'(d >> 1);
        return v;
    endfunction

    function automatic logic [31:0] nw(input int p, input int h);
        logic [31:0] v = '0;
        v[25:16] = 10'(p);
        v[9:0]   = 10'(h);
        return v;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // stage a setting with the channel stopped, release hold, then start it
    task automatic program_run(input int p, input int h, input int d);
        wr(4'h0, cw(0, 0, d));
        wr(4'h0, cw(0, 1, d));
        wr(4'h4, nw(p, h));
        wr(4'h0, cw(0, 0, d));
        @(negedge clk);
        wr(4'h0, cw(1, 0, d));
    endtask

    // sample two whole periods starting at count 0 (current negedge)
    task automatic window(input int p, input int h, input int d, input string req);
        int mism = 0;
        int hi   = 0;
        for (int j = 0; j < 2 * p * (1 << d); j++) begin
            if (j > 0) @(negedge clk);
            if (pwm_out !== (((j >> d) % p) < h)) mism++;
            if (pwm_out === 1'b1) hi++;
        end
        chk(mism == 0, req, hi, 2 * ((h < p) ? h : p) * (1 << d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); chk(v == 32'h0, "R1 ctrl", int'(v), 0);
        rd(4'h4, v); chk(v == 32'h0, "R1 count", int'(v), 0);
        chk(pwm_out == 1'b0, "R1 out", int'(pwm_out), 0);

        // R5 run refused with zero working values
        wr(4'h0, cw(1, 0, 0));
        rd(4'h0, v); chk(v[0] == 1'b0, "R5 run bit", int'(v[0]), 0);
        chk(pwm_out == 1'b0, "R5 out", int'(pwm_out), 0);

        // R11 / R2 count write visible next cycle
        wr(4'h4, nw(10, 3));
        rd(4'h4, v); chk(v == nw(10, 3), "R11 count readback", int'(v), int'(nw(10, 3)));

        // R4 zero fields refused
        wr(4'h4, nw(0, 5));
        rd(4'h4, v); chk(v == nw(10, 3), "R4 zero period", int'(v), int'(nw(10, 3)));
        wr(4'h4, nw(7, 0));
        rd(4'h4, v); chk(v == nw(10, 3), "R4 zero high", int'(v), int'(nw(10, 3)));

        // R3 exponent clamp
        wr(4'h0, cw(0, 0, 31));
        rd(4'h0, v); chk(v == cw(0, 0, 24), "R3 clamp", int'(v), int'(cw(0, 0, 24)));

        // R2 reserved bits read zero
        wr(4'h0, 32'hFFFF_F7FE);
        rd(4'h0, v); chk(v == cw(0, 0, 24), "R2 ctrl reserved", int'(v), int'(cw(0, 0, 24)));
        wr(4'h4, 32'hFC0A_FC03);
        rd(4'h4, v); chk(v == nw(10, 3), "R2 count reserved", int'(v), int'(nw(10, 3)));
        wr(4'h0, cw(0, 0, 0));

        // table walk
        for (int i = 0; i < NV; i++) begin
            program_run(V_PER[i], V_HIGH[i], V_EXP[i]);
            window(V_PER[i], V_HIGH[i], V_EXP[i], V_REQ[i]);
            wr(4'h0, cw(0, 0, V_EXP[i]));
            chk(pwm_out == 1'b0, "R10 stop", int'(pwm_out), 0);
        end

        // R10 stop mid-period and fresh restart
        program_run(8, 3, 1);
        repeat (5) @(negedge clk);
        wr(4'h0, cw(0, 0, 1));
        chk(pwm_out == 1'b0, "R10 mid stop", int'(pwm_out), 0);
        rd(4'h0, v); chk(v[0] == 1'b0, "R10 run bit", int'(v[0]), 0);
        wr(4'h0, cw(1, 0, 1));
        window(8, 3, 1, "R10 restart");

        // R8 hold keeps old waveform, R9 switch at boundary
        program_run(10, 3, 0);
        wr(4'h0, cw(1, 1, 0));
        wr(4'h4, nw(6, 5));
        begin
            int hi = 0;
            for (int j = 0; j < 20; j++) begin
                if (j > 0) @(negedge clk);
                if (pwm_out === 1'b1) hi++;
            end
            chk(hi == 6, "R8 held duty", hi, 6);
        end
        rd(4'h4, v); chk(v == nw(6, 5), "R8 staged", int'(v), int'(nw(6, 5)));
        wr(4'h0, cw(1, 0, 0));
        for (int k = 0; k < 40 && pwm_out !== 1'b0; k++) @(negedge clk);
        for (int k = 0; k < 40 && pwm_out !== 1'b1; k++) @(negedge clk);
        window(6, 5, 0, "R9 boundary switch");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule